// File: doc/BRIEF.md
# Scoped Memory Barrier Sequencer

This block sits between the issue stage of one thread and that thread's memory request port. Ordinary accesses (reads, writes, atomics) pass straight through to the memory port. Each access is counted at issue by four saturating counters, one for each visibility scope. The scopes are nested, from narrowest to widest: thread group, channel, device and system. The memory side returns acknowledges that carry a mask of the scopes an access has newly reached. Each set bit takes one from the matching counter.

When a barrier instruction arrives, it carries a scope and an invalidate option. The sequencer first sends any selected cache invalidate-all commands, one at a time, and waits for each to be acknowledged. It then waits until no earlier access is outstanding at the requested scope or at any narrower one. Counters for wider scopes are not checked.

While the barrier is pending, the block raises a combinational stall toward issue. That stall holds back every later access and any second barrier. Ordering is per thread only: the block never waits on other threads. Accesses within the earlier group, and within the later group, may complete in any order.

Top module: `membar_seq`

## Requirements
- R1: After reset every counter is zero and the sequencer is idle: stall, mem_valid and inv_valid are low, and a system-scope barrier with no invalidate completes at once.
- R2: When stall is low, an access on acc_valid is forwarded in the same cycle: mem_valid follows acc_valid and mem_op equals acc_op.
- R3: Each scope counter adds one for every forwarded access and subtracts one for every acknowledge whose ack_mask bit for that scope is set. A counter holds when both happen in the same cycle, stops at 2^CNT_W-1 and never goes below zero.
- R4: The scope encoding is 0 thread group, 1 channel, 2 device, 3 system. A barrier at scope s waits only until the counters for scopes 0 through s are all zero. Outstanding counts at wider scopes do not delay it.
- R5: While a barrier is pending, an access presented on acc_valid is neither forwarded nor counted.
- R6: A barrier with invalidate option 0 that finds its scope and all narrower scopes already clear completes in the cycle it is presented, with stall low in that cycle.
- R7: The invalidate option encoding is 0 none, 1 data cache, 2 texture cache, 3 both. Each selected command is held on inv_valid, with inv_tex 0 for data and 1 for texture, until inv_ack. For option 3 the data command goes first.
- R8: A barrier does not complete before every selected invalidate has been acknowledged, even when no access is outstanding. Stall stays high while inv_valid is high.
- R9: Stall is low in the cycle a pending barrier completes, and the next access or barrier is accepted in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Memory access presented by issue |
| acc_op | input | OP_W | Access operation code, passed through |
| bar_valid | input | 1 | Barrier presented by issue |
| bar_scope | input | 2 | Barrier scope (0 group, 1 channel, 2 device, 3 system) |
| bar_inval | input | 2 | Invalidate option (0 none, 1 data, 2 texture, 3 both) |
| stall | output | 1 | Hold-off toward issue, combinational |
| mem_valid | output | 1 | Access forwarded to the memory port |
| mem_op | output | OP_W | Operation code of the forwarded access |
| ack_valid | input | 1 | Visibility acknowledge from memory side |
| ack_mask | input | 4 | Scopes newly reached by one earlier access |
| inv_valid | output | 1 | Invalidate-all command pending |
| inv_tex | output | 1 | 0 data cache, 1 texture cache |
| inv_ack | input | 1 | Invalidate command acknowledged |

## Verification
Counter saturation is the hardest case to reach from the ports. The stimulus issues sixteen accesses with no acknowledge, so the counters stop at their limit. It then returns only fifteen acknowledges and checks that the barrier is released, which shows that one count was lost on purpose. The bench also delays invalidate acknowledges so that the data-then-texture order and the barrier's wait on them can be seen with no access outstanding. It also presents an access in the middle of a pending barrier to show that the access is not counted.

// File: rtl/membar_pkg.sv
package membar_pkg;
  localparam int NSCOPE = 4;
  localparam int SCW    = $clog2(NSCOPE);

  typedef enum logic [1:0] {
    SC_GROUP = 2'd0,
    SC_CHAN  = 2'd1,
    SC_DEV   = 2'd2,
    SC_SYS   = 2'd3
  } scope_e;

  typedef enum logic [1:0] {
    INV_NONE = 2'd0,
    INV_DATA = 2'd1,
    INV_TEX  = 2'd2,
    INV_BOTH = 2'd3
  } inval_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INV_D = 2'd1,
    ST_INV_T = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/membar_sat_cnt.sv
module membar_sat_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;
  logic         full;

  assign full = (cnt_q == CMAX);
  assign zero = (cnt_q == '0);
  assign cnt  = cnt_q;

  // Clock enable only when the value really moves; saturate at both ends.
  assign cnt_en = (inc & ~dec & ~full) | (dec & ~inc & ~zero);

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec)      cnt_d = cnt_q + 1'b1;
    else if (dec && !inc) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/membar_scope_clear.sv
module membar_scope_clear
  import membar_pkg::*;
(
  input  logic [NSCOPE-1:0] zero_vec,
  input  logic [SCW-1:0]    scope,
  output logic              clear
);
  logic [NSCOPE-1:0] lvl_ok;

  // A scope wider than the requested one never blocks the barrier.
  for (genvar i = 0; i < NSCOPE; i++) begin : g_lvl
    assign lvl_ok[i] = zero_vec[i] | (i > int'(scope));
  end

  assign clear = &lvl_ok;
endmodule

// File: rtl/membar_ctl.sv
module membar_ctl
  import membar_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bar_valid,
  input  logic [SCW-1:0] bar_scope,
  input  logic [1:0]     bar_inval,
  input  logic           inv_ack,
  input  logic           scope_clear,
  output logic           stall,
  output logic           inv_valid,
  output logic           inv_tex,
  output logic [SCW-1:0] eff_scope
);
  seq_state_e     state_q, state_d;
  logic [SCW-1:0] scope_q;
  logic [1:0]     inval_q;
  logic           capture;

  // Idle: judge the arriving barrier; otherwise: the held one.
  assign eff_scope = (state_q == ST_IDLE) ? bar_scope : scope_q;
  assign inv_valid = (state_q == ST_INV_D) || (state_q == ST_INV_T);
  assign inv_tex   = (state_q == ST_INV_T);

  always_comb begin
    state_d = state_q;
    stall   = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (bar_valid && !(bar_inval == INV_NONE && scope_clear)) begin
          stall   = 1'b1;
          capture = 1'b1;
          if (bar_inval[0])      state_d = ST_INV_D;
          else if (bar_inval[1]) state_d = ST_INV_T;
          else                   state_d = ST_DRAIN;
        end
      end
      ST_INV_D: begin
        stall = 1'b1;
        if (inv_ack) state_d = inval_q[1] ? ST_INV_T : ST_DRAIN;
      end
      ST_INV_T: begin
        stall = 1'b1;
        if (inv_ack) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        stall = ~scope_clear;
        if (scope_clear) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scope_q <= '0;
      inval_q <= '0;
    end else if (capture) begin
      scope_q <= bar_scope;
      inval_q <= bar_inval;
    end
  end
endmodule

// File: rtl/membar_seq.sv
module membar_seq
  import membar_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int OP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [OP_W-1:0]   acc_op,
  input  logic              bar_valid,
  input  logic [SCW-1:0]    bar_scope,
  input  logic [1:0]        bar_inval,
  output logic              stall,
  output logic              mem_valid,
  output logic [OP_W-1:0]   mem_op,
  input  logic              ack_valid,
  input  logic [NSCOPE-1:0] ack_mask,
  output logic              inv_valid,
  output logic              inv_tex,
  input  logic              inv_ack
);
  localparam int CNT_BITS = NSCOPE * CNT_W;

  logic [NSCOPE-1:0] zero_vec;
  logic [CNT_BITS-1:0] cnt_flat;
  logic [SCW-1:0]    eff_scope;
  logic              scope_clear;
  logic              issue_go;

  assign issue_go  = acc_valid & ~stall;
  assign mem_valid = issue_go;
  assign mem_op    = acc_op;

  for (genvar g = 0; g < NSCOPE; g++) begin : g_scope
    membar_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (issue_go),
      .dec  (ack_valid & ack_mask[g]),
      .cnt  (cnt_flat[g*CNT_W +: CNT_W]),
      .zero (zero_vec[g])
    );
  end

  membar_scope_clear u_clr (
    .zero_vec(zero_vec),
    .scope   (eff_scope),
    .clear   (scope_clear)
  );

  membar_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bar_valid  (bar_valid),
    .bar_scope  (bar_scope),
    .bar_inval  (bar_inval),
    .inv_ack    (inv_ack),
    .scope_clear(scope_clear),
    .stall      (stall),
    .inv_valid  (inv_valid),
    .inv_tex    (inv_tex),
    .eff_scope  (eff_scope)
  );
endmodule

// File: rtl/membar_seq_chk.sv
module membar_seq_chk
  import membar_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    stall,
  input logic                    mem_valid,
  input logic                    ack_valid,
  input logic [NSCOPE-1:0]       ack_mask,
  input logic                    inv_valid,
  input logic                    inv_tex,
  input logic                    inv_ack,
  input logic [NSCOPE*CNT_W-1:0] cnt_flat,
  input logic [SCW-1:0]          eff_scope
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt0;
  logic             past_ok;

  assign cnt0 = cnt_flat[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  function automatic logic lower_clear(input logic [NSCOPE*CNT_W-1:0] c,
                                       input logic [SCW-1:0] s);
    for (int i = 0; i < NSCOPE; i++)
      if (i <= int'(s) && c[i*CNT_W +: CNT_W] != '0) return 1'b0;
    return 1'b1;
  endfunction

  // R3: a counter at zero ignores a further acknowledge
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 == '0 && ack_valid && ack_mask[0] && !mem_valid) |=> (cnt0 == '0));

  // R3: a counter at its limit ignores a further access
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 == CMAX && mem_valid && !(ack_valid && ack_mask[0])) |=> (cnt0 == CMAX));

  // R4: release happens only with the requested and narrower scopes clear
  p_release_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(stall) && !inv_valid) |-> lower_clear(cnt_flat, eff_scope));

  // R7: a command stays up and unchanged until it is acknowledged
  p_inv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_ack) |=> (inv_valid && $stable(inv_tex)));

  // R7: the texture command is always the last one of a barrier
  p_tex_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_tex && inv_ack) |=> !inv_valid);

  // R8: issue stays held while a command is outstanding
  p_inv_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> stall);
endmodule

bind membar_seq membar_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stall    (stall),
  .mem_valid(mem_valid),
  .ack_valid(ack_valid),
  .ack_mask (ack_mask),
  .inv_valid(inv_valid),
  .inv_tex  (inv_tex),
  .inv_ack  (inv_ack),
  .cnt_flat (cnt_flat),
  .eff_scope(eff_scope)
);

// File: tb/membar_seq_test.sv
module membar_seq_test;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;
  localparam int NS   = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       acc_valid;
  logic [1:0] acc_op;
  logic       bar_valid;
  logic [1:0] bar_scope;
  logic [1:0] bar_inval;
  logic       stall;
  logic       mem_valid;
  logic [1:0] mem_op;
  logic       ack_valid;
  logic [3:0] ack_mask;
  logic       inv_valid;
  logic       inv_tex;
  logic       inv_ack;

  membar_seq #(.CNT_W(CW), .OP_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_op(acc_op),
    .bar_valid(bar_valid), .bar_scope(bar_scope), .bar_inval(bar_inval),
    .stall(stall), .mem_valid(mem_valid), .mem_op(mem_op),
    .ack_valid(ack_valid), .ack_mask(ack_mask),
    .inv_valid(inv_valid), .inv_tex(inv_tex), .inv_ack(inv_ack)
  );

  // Reference model state
  int    cnt_m[NS];
  int    ph;        // 0 idle, 1 data inval, 2 texture inval, 3 drain
  int    hs, hinv, inv_age, inv_lat;
  int    ackq[$];
  int    invseq[$];
  int    last_stall;
  string tag;
  int    n_chk, n_fail;
  bit    finished;

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit drained_m(int s);
    for (int i = 0; i <= s; i++) if (cnt_m[i] != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic cyc();
    int es, em, ei, et, am;
    bit ia, d;
    if (ackq.size() > 0) begin
      am = ackq.pop_front();
      ack_valid = 1'b1; ack_mask = am[3:0];
    end else begin
      ack_valid = 1'b0; ack_mask = '0;
    end
    ia = ((ph == 1) || (ph == 2)) && (inv_age >= inv_lat);
    inv_ack = ia;
    #2;
    case (ph)
      0:       es = (bar_valid && !(bar_inval == 2'd0 && drained_m(int'(bar_scope)))) ? 1 : 0;
      1, 2:    es = 1;
      default: es = drained_m(hs) ? 0 : 1;
    endcase
    em = (acc_valid && es == 0) ? 1 : 0;
    ei = (ph == 1 || ph == 2) ? 1 : 0;
    et = (ph == 2) ? 1 : 0;
    chk(tag, int'(stall), es, "stall");
    chk(tag, int'(mem_valid), em, "mem_valid");
    if (em != 0) chk(tag, int'(mem_op), int'(acc_op), "mem_op");
    chk(tag, int'(inv_valid), ei, "inv_valid");
    if (ei != 0) chk(tag, int'(inv_tex), et, "inv_tex");
    if (ia && inv_valid) invseq.push_back(int'(inv_tex));
    last_stall = es;
    @(posedge clk);
    for (int i = 0; i < NS; i++) begin
      d = ack_valid && ack_mask[i];
      if (em != 0 && !d && cnt_m[i] < CMAX) cnt_m[i]++;
      else if (em == 0 && d && cnt_m[i] > 0) cnt_m[i]--;
    end
    case (ph)
      0: if (bar_valid && es != 0) begin
           hs = int'(bar_scope); hinv = int'(bar_inval); inv_age = 0;
           ph = bar_inval[0] ? 1 : (bar_inval[1] ? 2 : 3);
         end
      1: if (ia) begin ph = (hinv >= 2) ? 2 : 3; inv_age = 0; end
         else inv_age++;
      2: if (ia) begin ph = 3; inv_age = 0; end
         else inv_age++;
      default: if (es == 0) ph = 0;
    endcase
    #1;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic issue(int op);
    acc_valid = 1'b1; acc_op = op[1:0];
    cyc();
    acc_valid = 1'b0;
  endtask

  task automatic run_bar(int s, int v, output int ncyc);
    bar_scope = s[1:0]; bar_inval = v[1:0]; bar_valid = 1'b1;
    ncyc = 0;
    do begin
      cyc();
      ncyc++;
    end while (last_stall != 0 && ncyc < 500);
    bar_valid = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n;
    n_chk = 0; n_fail = 0; finished = 1'b0;
    for (int i = 0; i < NS; i++) cnt_m[i] = 0;
    ph = 0; hs = 0; hinv = 0; inv_age = 0; inv_lat = 0;
    rst_n = 1'b0; acc_valid = 1'b0; acc_op = '0; bar_valid = 1'b0;
    bar_scope = '0; bar_inval = '0; ack_valid = 1'b0; ack_mask = '0; inv_ack = 1'b0;
    repeat (3) @(posedge clk);
    #4;
    chk("R1", int'(stall), 0, "stall in reset");
    chk("R1", int'(inv_valid), 0, "inv_valid in reset");
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R1: idle state, system barrier completes at once
    tag = "R1";
    idle(2);
    run_bar(3, 0, n);
    chk("R1", n, 1, "cycles of first barrier");

    // R2: pass-through of each operation code
    tag = "R2";
    issue(0); issue(1); issue(2); issue(3);
    for (int k = 0; k < 4; k++) ackq.push_back(4'b1111);
    idle(5);

    // R4: group barrier ignores outstanding wider scopes
    tag = "R4";
    issue(1); issue(1); issue(1);
    for (int k = 0; k < 3; k++) ackq.push_back(4'b0001);
    run_bar(0, 0, n);
    chk("R4", n, 4, "group barrier cycles");
    for (int k = 0; k < 3; k++) ackq.push_back(4'b1110);
    run_bar(1, 0, n);
    chk("R4", n, 4, "channel barrier cycles");

    // R5: access presented mid-barrier is neither forwarded nor counted
    tag = "R5";
    issue(0); issue(0);
    bar_scope = 2'd2; bar_inval = 2'd0; bar_valid = 1'b1;
    idle(2);
    bar_valid = 1'b0; acc_valid = 1'b1; acc_op = 2'd1;
    cyc();
    chk("R5", int'(mem_valid), 0, "blocked access");
    acc_valid = 1'b0;
    ackq.push_back(4'b0111); ackq.push_back(4'b0111);
    run_bar(2, 0, n);
    chk("R5", n, 3, "release after real acks only");
    ackq.push_back(4'b1000); ackq.push_back(4'b1000);
    idle(3);

    // R6: immediate completion, including with wider scopes busy
    tag = "R6";
    run_bar(3, 0, n);
    chk("R6", n, 1, "clear barrier cycles");
    issue(2);
    ackq.push_back(4'b0001);
    idle(2);
    run_bar(0, 0, n);
    chk("R6", n, 1, "group barrier with wider counts");
    ackq.push_back(4'b1110);
    idle(2);

    // R7 and R8: both invalidates, data then texture, barrier waits
    tag = "R8";
    inv_lat = 3; invseq.delete();
    run_bar(3, 3, n);
    chk("R8", n, 10, "barrier with both invalidates");
    chk("R7", invseq.size(), 2, "command count");
    if (invseq.size() == 2) begin
      chk("R7", invseq[0], 0, "first command is data");
      chk("R7", invseq[1], 1, "second command is texture");
    end

    tag = "R7";
    issue(1); issue(1);
    inv_lat = 0; invseq.delete();
    ackq.push_back(4'b1111); ackq.push_back(4'b1111);
    run_bar(3, 1, n);
    chk("R7", n, 3, "data-only barrier cycles");
    chk("R7", invseq.size(), 1, "data-only command count");
    if (invseq.size() == 1) chk("R7", invseq[0], 0, "data-only kind");
    inv_lat = 1; invseq.delete();
    run_bar(2, 2, n);
    chk("R7", n, 4, "texture-only barrier cycles");
    if (invseq.size() == 1) chk("R7", invseq[0], 1, "texture-only kind");
    else chk("R7", invseq.size(), 1, "texture-only command count");

    // R3: saturation, underflow and simultaneous update
    tag = "R3";
    for (int k = 0; k < 16; k++) issue(0);
    for (int k = 0; k < 15; k++) ackq.push_back(4'b1111);
    run_bar(3, 0, n);
    chk("R3", n, 16, "saturated counter drains with fifteen acks");
    ackq.push_back(4'b1111); ackq.push_back(4'b1111);
    idle(2);
    issue(2);
    ackq.push_back(4'b1111);
    run_bar(3, 0, n);
    chk("R3", n, 2, "no wrap below zero");
    issue(1);
    ackq.push_back(4'b1111);
    issue(1);
    ackq.push_back(4'b1111);
    run_bar(3, 0, n);
    chk("R3", n, 2, "same-cycle add and subtract");

    // R9: back-to-back release and acceptance
    tag = "R9";
    issue(3);
    ackq.push_back(4'b1111);
    run_bar(1, 0, n);
    chk("R9", last_stall, 0, "stall low in completion cycle");
    issue(0);
    chk("R9", int'(mem_valid), 1, "access accepted next cycle");
    ackq.push_back(4'b1111);
    run_bar(3, 0, n);
    chk("R9", n, 2, "following barrier");
    idle(2);

    summary();
  end
endmodule